// File: doc/BRIEF.md
# Seven-Level Stacked-Carrier PWM Modulator

This block produces the gate commands for one leg of a seven-level clamped converter. A signed reference sample is compared against six triangular carriers that are stacked on top of one another and kept exactly in phase. Each carrier band owns one complementary switch pair. While the reference lies above a band's carrier, that pair's "up" switch is commanded on. Otherwise its "down" switch is commanded on. Every change of a pair's command first turns both switches of the pair off for a programmable lockout. The count of bands the reference lies above, minus three, is reported as the output level code, from -3 to +3.

All carriers come from one shared up/down counter. Each band's threshold is that counter plus the band's fixed floor. The reference enters through a valid/ready port, and one sample is taken per carrier period, at the carrier top. `ref_ready` is high for exactly one cycle at that point. A sample moves only when `ref_valid` and `ref_ready` are both high. If the source does not offer valid data at the top, the previous sample stays in force for another full period. The source may hold `ref_valid` high permanently. In that case the block simply picks up whatever `ref_in` carries at each top.

Top module: `pd7_modulator`

## Requirements
- R1: While `rst` is high, and on the clock after `en` is sampled low, every bit of `gate_up` and `gate_dn` is 0 and `ref_ready` is 0. After reset, `level_o` reads -3.
- R2: While enabled, the carrier counter runs 0,1,…,PEAK,PEAK-1,…,1 and repeats, so one period is 2·PEAK clocks. `ref_ready` is high for exactly one clock per period, when the counter equals PEAK.
- R3: The stored reference changes only on a clock where `ref_valid` and `ref_ready` are both high. Otherwise the previous sample is kept.
- R4: Band k (k = 0 bottom … 5 top) compares the stored reference against the threshold (k-3)·PEAK + counter. A band counts as "above" only when the reference is strictly greater than its threshold.
- R5: `level_o` is the number of bands that are above, minus 3, in 3-bit two's complement (-3 = 3'b101, +3 = 3'b011). It follows the carrier by one register.
- R6: While the stored reference is constant, `level_o` moves by at most one step per clock, so only one pair changes its command per level step.
- R7: When settled, `gate_up[k]` is on while band k is above, and `gate_dn[k]` is on while it is not. Bit 5 belongs to the top carrier and bit 0 to the bottom carrier. A constant level L therefore gives `gate_up` equal to the lowest L+3 bits set.
- R8: `gate_up[k]` and `gate_dn[k]` are never high in the same cycle.
- R9: When a pair's command changes, both of its gates read 0 for exactly max(`dead_cycles`,1) clocks. After that, the newly selected gate turns on.
- R10: `dead_cycles` is captured at the clock where a pair's command change is detected. A later change of `dead_cycles` does not alter a lockout already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces all gates off and parks the carrier at 0 |
| ref_in | input | REF_W | Signed reference, full scale ±3·PEAK |
| ref_valid | input | 1 | Reference word is valid |
| ref_ready | output | 1 | Block takes a reference this cycle (carrier top) |
| dead_cycles | input | DT_W | Lockout length in clocks per pair command change |
| gate_up | output | 6 | Per-pair switch on while the reference is above that band |
| gate_dn | output | 6 | Per-pair complementary switch |
| level_o | output | 3 | Signed output level code, -3 … +3 |

## Verification
The assertions watch several properties on every clock. They check that the two gates of a pair never overlap, that a gate turning on after its partner waited out the captured lockout, and that the gates drop after a disabled clock. They also check that the carrier stays in range and steps by one, that the top pulse lasts one cycle, that the stored reference moves only on a handshake, and that the level never jumps by more than one step between samples. Other behaviour can only be shown by the bench's scenarios. This covers the exact level range and the per-period sum of active bands for a set of references, including references exactly on band edges and beyond full scale. It also covers the settled gate patterns at the extremes, the exact lockout lengths including a zero setting and a mid-lockout change of `dead_cycles`, the held sample under back-pressure, and the reset and disable states.

// File: rtl/pd7_pkg.sv
package pd7_pkg;
  localparam int NUM_BANDS  = 6;
  localparam int HALF_BANDS = NUM_BANDS / 2;
  localparam int LVL_W      = 3;

  typedef logic [NUM_BANDS-1:0] band_vec_t;

  // Floor of band k in reference units: bands stacked symmetrically about zero.
  function automatic int band_floor(input int k, input int peak);
    return (k - HALF_BANDS) * peak;
  endfunction
endpackage

// File: rtl/pd7_carrier.sv
module pd7_carrier #(
  parameter int PEAK  = 2500,
  parameter int CNT_W = $clog2(PEAK + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             apex_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(PEAK);

  logic rising;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_o  <= '0;
      rising <= 1'b1;
    end else if (rising) begin
      cnt_o <= cnt_o + 1'b1;
      if (cnt_o == TOP - 1'b1) rising <= 1'b0;
    end else begin
      cnt_o <= cnt_o - 1'b1;
      if (cnt_o == CNT_W'(1)) rising <= 1'b1;
    end
  end

  assign apex_o = en && !rst && (cnt_o == TOP);

  // R2: counter never leaves 0..PEAK
  a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= TOP);

  // R2: carrier moves by exactly one count per enabled clock
  a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !$past(rst)) |->
      (cnt_o == $past(cnt_o) + 1'b1 || cnt_o == $past(cnt_o) - 1'b1));

  // R2: the sampling point lasts a single clock
  a_r2_apex_single: assert property (@(posedge clk) disable iff (rst)
    apex_o |=> !apex_o);
endmodule

// File: rtl/pd7_bands.sv
module pd7_bands
  import pd7_pkg::*;
#(
  parameter int REF_W = 16,
  parameter int PEAK  = 2500,
  parameter int CNT_W = $clog2(PEAK + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [REF_W-1:0] ref_s,
  input  logic        [CNT_W-1:0] cnt,
  output band_vec_t               above_q
);
  localparam int CW = ((REF_W > CNT_W + 3) ? REF_W : CNT_W + 3) + 1;

  logic signed [CW-1:0] ref_w;
  logic signed [CW-1:0] tri_w;
  band_vec_t            above_d;

  assign ref_w = $signed({{(CW-REF_W){ref_s[REF_W-1]}}, ref_s});
  assign tri_w = $signed({{(CW-CNT_W){1'b0}}, cnt});

  for (genvar k = 0; k < NUM_BANDS; k++) begin : g_band
    localparam logic signed [CW-1:0] FLOOR = CW'(band_floor(k, PEAK));
    assign above_d[k] = ref_w > (FLOOR + tri_w);
  end

  always_ff @(posedge clk) begin
    if (rst) above_q <= '0;
    else     above_q <= above_d;
  end

  // R4: stacked bands are ordered, so the active set is a thermometer from band 0
  a_r4_thermometer: assert property (@(posedge clk) disable iff (rst)
    (above_q & (above_q + 1'b1)) == '0);
endmodule

// File: rtl/pd7_deadband.sv
module pd7_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            cmd,
  input  logic [DT_W-1:0] dt_i,
  output logic            gate_up_o,
  output logic            gate_dn_o
);
  logic            tgt;
  logic [DT_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt       <= 1'b0;
      hold      <= '0;
      gate_up_o <= 1'b0;
      gate_dn_o <= 1'b0;
    end else if (!en || cmd != tgt) begin
      tgt       <= cmd;
      hold      <= dt_i;
      gate_up_o <= 1'b0;
      gate_dn_o <= 1'b0;
    end else if (hold > DT_W'(1)) begin
      hold      <= hold - 1'b1;
      gate_up_o <= 1'b0;
      gate_dn_o <= 1'b0;
    end else begin
      hold      <= '0;
      gate_up_o <= tgt;
      gate_dn_o <= !tgt;
    end
  end

  // Checker state: off-run length, last conducting side, lockout captured at the change
  logic [DT_W:0]   off_run;
  logic            seen_on;
  logic            last_up;
  logic [DT_W-1:0] dt_lat;
  logic [DT_W:0]   dt_need;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_run <= '0;
      seen_on <= 1'b0;
      last_up <= 1'b0;
      dt_lat  <= '0;
    end else begin
      if (gate_up_o || gate_dn_o) off_run <= '0;
      else if (!(&off_run))       off_run <= off_run + 1'b1;
      if (gate_up_o || gate_dn_o) seen_on <= 1'b1;
      if (gate_up_o)      last_up <= 1'b1;
      else if (gate_dn_o) last_up <= 1'b0;
      if (!en || cmd != tgt) dt_lat <= dt_i;
    end
  end

  assign dt_need = (dt_lat == '0) ? (DT_W+1)'(1) : {1'b0, dt_lat};

  // R8: the two switches of a pair never conduct together
  a_r8_pair_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gate_up_o && gate_dn_o));

  // R1: a disabled clock leaves both gates off
  a_r1_off_after_disable: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!gate_up_o && !gate_dn_o));

  // R9, R10: a side swap waits at least the lockout captured at the change
  a_r9_lockout: assert property (@(posedge clk) disable iff (rst)
    (seen_on && ((gate_up_o && !$past(gate_up_o) && !last_up) ||
                 (gate_dn_o && !$past(gate_dn_o) &&  last_up)))
      |-> (off_run >= dt_need));
endmodule

// File: rtl/pd7_modulator.sv
module pd7_modulator
  import pd7_pkg::*;
#(
  parameter int REF_W = 16,
  parameter int PEAK  = 2500,
  parameter int DT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [REF_W-1:0] ref_in,
  input  logic                    ref_valid,
  output logic                    ref_ready,
  input  logic        [DT_W-1:0]  dead_cycles,
  output logic [NUM_BANDS-1:0]    gate_up,
  output logic [NUM_BANDS-1:0]    gate_dn,
  output logic signed [LVL_W-1:0] level_o
);
  localparam int CNT_W = $clog2(PEAK + 1);

  logic [CNT_W-1:0]        cnt;
  logic                    apex;
  logic signed [REF_W-1:0] ref_s;
  band_vec_t               band_q;

  pd7_carrier #(.PEAK(PEAK), .CNT_W(CNT_W)) u_carrier (
    .clk(clk), .rst(rst), .en(en), .cnt_o(cnt), .apex_o(apex)
  );

  assign ref_ready = apex;

  always_ff @(posedge clk) begin
    if (rst)                         ref_s <= '0;
    else if (ref_valid && ref_ready) ref_s <= ref_in;
  end

  pd7_bands #(.REF_W(REF_W), .PEAK(PEAK), .CNT_W(CNT_W)) u_bands (
    .clk(clk), .rst(rst), .ref_s(ref_s), .cnt(cnt), .above_q(band_q)
  );

  assign level_o = LVL_W'($countones(band_q)) - LVL_W'(HALF_BANDS);

  for (genvar k = 0; k < NUM_BANDS; k++) begin : g_pair
    pd7_deadband #(.DT_W(DT_W)) u_lock (
      .clk(clk), .rst(rst), .en(en), .cmd(band_q[k]), .dt_i(dead_cycles),
      .gate_up_o(gate_up[k]), .gate_dn_o(gate_dn[k])
    );
  end

  // Checker: consecutive enabled clocks, so level history covers a clean carrier run
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst || !en)       warm <= '0;
    else if (warm != 2'd3) warm <= warm + 1'b1;
  end

  // R3: the stored reference moves only on an accepted handshake
  a_r3_hold_without_handshake: assert property (@(posedge clk) disable iff (rst)
    !(ref_valid && ref_ready) |=> $stable(ref_s));

  // R6: with a steady sample the level steps by at most one per clock
  a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(ref_s) == $past(ref_s, 2)) |->
      (($countones(band_q) <= $countones($past(band_q)) + 1) &&
       ($countones($past(band_q)) <= $countones(band_q) + 1)));

  // R5: the level code stays inside -3..+3
  a_r5_level_range: assert property (@(posedge clk) disable iff (rst)
    level_o != 3'b100);
endmodule

// File: tb/tb_pd7_modulator.sv
module tb_pd7_modulator;
  localparam int REF_W = 8;
  localparam int PEAK  = 8;
  localparam int DT_W  = 4;
  localparam int PER   = 2 * PEAK;
  localparam int NV    = 11;
  localparam int REFS [NV] = '{-24, -20, -9, -1, 0, 5, 12, 23, 24, 40, -40};
  localparam int LMIN [NV] = '{ -3,  -3, -2, -1, -1, 0, 1, 2, 2, 3, -3};
  localparam int LMAX [NV] = '{ -3,  -2, -1,  0,  0, 1, 2, 3, 3, 3, -3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic signed [REF_W-1:0] ref_in = '0;
  logic ref_valid = 1'b0;
  logic ref_ready;
  logic [DT_W-1:0] dead_cycles = 4'd2;
  logic [5:0] gate_up, gate_dn;
  logic signed [2:0] level_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pd7_modulator #(.REF_W(REF_W), .PEAK(PEAK), .DT_W(DT_W)) dut (
    .clk(clk), .rst(rst), .en(en), .ref_in(ref_in), .ref_valid(ref_valid),
    .ref_ready(ref_ready), .dead_cycles(dead_cycles), .gate_up(gate_up),
    .gate_dn(gate_dn), .level_o(level_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Active-band total over one full carrier period, from the stacking rule
  function automatic int model_sum(input int r);
    int s = 0;
    for (int i = 0; i < PER; i++) begin
      int c = (i <= PEAK) ? i : PER - i;
      for (int k = 0; k < 6; k++) if (r > (k - 3) * PEAK + c) s++;
    end
    return s;
  endfunction

  task automatic window(output int lo, output int hi, output int sum, output int step);
    int prev = 0;
    lo = 99; hi = -99; sum = 0; step = 0;
    for (int i = 0; i < PER; i++) begin
      int l;
      @(negedge clk);
      l = int'(level_o);
      if (l < lo) lo = l;
      if (l > hi) hi = l;
      sum += l + 3;
      if (i > 0 && (l - prev > step || prev - l > step)) step = (l > prev) ? l - prev : prev - l;
      prev = l;
    end
  endtask

  task automatic measure_gap(input int tgt_ref, input int new_dt, output int gap, output int overl);
    int guard = 0;
    gap = 0; overl = 0;
    ref_in = REF_W'(tgt_ref);
    do begin @(negedge clk); guard++; if ((gate_up & gate_dn) != 0) overl++; end
    while ((gate_up | gate_dn) != 6'h00 && guard < 100);
    if (new_dt >= 0) dead_cycles = DT_W'(new_dt);
    while ((gate_up | gate_dn) == 6'h00 && guard < 200) begin
      gap++;
      @(negedge clk); guard++;
      if ((gate_up & gate_dn) != 0) overl++;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        n_bad++; n_cmp++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int lo, hi, sum, step, gap, ov, rdy;
    wait_cyc(5);
    // R1, R5: reset state
    chk("R1 gate_up in reset", int'(gate_up), 0);
    chk("R1 gate_dn in reset", int'(gate_dn), 0);
    chk("R1 ref_ready in reset", int'(ref_ready), 0);
    chk("R5 level code -3 encoding", int'({29'b0, level_o}), 5);
    rst = 1'b0; en = 1'b1; ref_valid = 1'b1;

    // Vector table: one reference per row, checked over a settled period
    for (int v = 0; v < NV; v++) begin
      ref_in = REF_W'(REFS[v]);
      wait_cyc(3 * PER);
      window(lo, hi, sum, step);
      chk($sformatf("R4 min level ref=%0d", REFS[v]), lo, LMIN[v]);
      chk($sformatf("R4 max level ref=%0d", REFS[v]), hi, LMAX[v]);
      chk($sformatf("R5 period band sum ref=%0d", REFS[v]), sum, model_sum(REFS[v]));
      chk($sformatf("R6 largest step ref=%0d", REFS[v]), (step > 1) ? step : 1, 1);
      if (LMIN[v] == LMAX[v]) begin
        chk($sformatf("R7 gate_up ref=%0d", REFS[v]), int'(gate_up), (1 << (LMIN[v] + 3)) - 1);
        chk($sformatf("R7 gate_dn ref=%0d", REFS[v]), int'(gate_dn), 63 - ((1 << (LMIN[v] + 3)) - 1));
      end
    end

    // R2: one ready pulse per carrier period
    rdy = 0;
    for (int i = 0; i < 3 * PER; i++) begin @(negedge clk); rdy += int'(ref_ready); end
    chk("R2 ready pulses in three periods", rdy, 3);

    // R9: full swing, lockout 5
    dead_cycles = 4'd5;
    wait_cyc(2);
    measure_gap(40, -1, gap, ov);
    chk("R9 lockout length dt=5", gap, 5);
    chk("R8 overlap during swing", ov, 0);
    chk("R9 new side on after lockout", int'(gate_up), 63);
    // R10: dead_cycles changed while a lockout of 3 runs
    dead_cycles = 4'd3;
    wait_cyc(2);
    measure_gap(-40, 7, gap, ov);
    chk("R10 lockout keeps captured value", gap, 3);
    chk("R10 complementary side on", int'(gate_dn), 63);
    // R9: zero setting still gives one clock
    dead_cycles = 4'd0;
    wait_cyc(2);
    measure_gap(40, -1, gap, ov);
    chk("R9 lockout length dt=0", gap, 1);
    chk("R8 overlap with zero lockout", ov, 0);

    // R3: back-pressure holds the previous sample
    ref_valid = 1'b0; ref_in = -8'sd40;
    wait_cyc(3 * PER);
    window(lo, hi, sum, step);
    chk("R3 level held without valid (min)", lo, 3);
    chk("R3 level held without valid (max)", hi, 3);
    ref_valid = 1'b1;
    wait_cyc(3 * PER);
    window(lo, hi, sum, step);
    chk("R3 sample taken once valid", hi, -3);

    // R1: enable low forces gates off
    en = 1'b0;
    wait_cyc(1);
    chk("R1 gate_up disabled", int'(gate_up), 0);
    chk("R1 gate_dn disabled", int'(gate_dn), 0);
    chk("R1 ready disabled", int'(ref_ready), 0);
    en = 1'b1;
    wait_cyc(3 * PER);
    chk("R7 gates restored after enable", int'(gate_dn), 63);

    // R1: reset mid-run
    rst = 1'b1;
    wait_cyc(2);
    chk("R1 gates off in mid-run reset", int'(gate_up | gate_dn), 0);
    chk("R5 level after mid-run reset", int'(level_o), -3);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule